// File: doc/BRIEF.md
# DAC Data Latch and Update Controller

This block is the digital front end of a multi-channel digital-to-analogue converter, sized by default for two channels. A host writes a data word for each channel through a small register port. The block converts each word to a straight-binary code at 8-bit or 12-bit resolution and holds it as a pending value. It then moves that value into the output code register that drives the converter core. Each channel chooses the event that moves its pending value: the write itself, a group event that changes all channels on the same cycle, or a rising edge on one of two asynchronous timer compare inputs.

Each output code register loads only on its selected trigger and holds its value between loads. Every load produces a one-cycle request pulse, which can serve as a DMA request. It also sets a sticky interrupt flag that the host clears by writing a one to it. The analogue core, the reference, gain and calibration are not part of this block.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset every output code is 0, every request pulse and interrupt flag is 0, and every channel is in immediate mode with 12-bit straight-binary input.
- R2: Address map: `wr_addr` 0 and 1 write the data word of channel 0 and channel 1. Addresses 2 and 3 write the control word of channel 0 and channel 1. Control word bits: [1:0] trigger select (0 immediate, 1 group, 2 timer A, 3 timer B), bit 2 selects 8-bit resolution when 1, bit 3 selects two's complement input when 1. A control write never changes an output code.
- R3: In 12-bit mode the code is the low 12 bits of the data word. For two's complement input, bit 11 is inverted.
- R4: In 8-bit mode the code is the low 8 bits of the data word, with bit 7 inverted for two's complement input. Code bits 11:8 are 0.
- R5: In immediate mode the output code takes the converted word on the same clock edge that samples the data write.
- R6: In group mode a write only marks its channel. Outputs do not change until every channel has been marked. On the next edge after that, all channels load together and the marks clear.
- R7: In timer-A mode a channel loads its pending value on the third clock edge after `tmr_a` rises. A falling edge, and any activity on `tmr_b`, leave that channel unchanged.
- R8: In timer-B mode the same rule applies to `tmr_b`, and `tmr_a` has no effect.
- R9: Between loads an output code holds. A trigger with no new write since the last load reloads the same value.
- R10: `upd_pulse[i]` is high for exactly the one cycle in which channel i's output code has just loaded.
- R11: `irq_flag[i]` is set by every load of channel i and stays set until `flag_clr[i]` is sampled high. When a load and a clear fall on the same edge, the load wins.
- R12: Resolution and format are applied when the data word is written. A later control write does not alter a value that is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (data 0..1, control 2..3) |
| wr_data | input | 12 | Write data: data word or control word |
| flag_clr | input | 2 | Write-one-to-clear strobes for the interrupt flags |
| tmr_a | input | 1 | Asynchronous timer compare trigger A |
| tmr_b | input | 1 | Asynchronous timer compare trigger B |
| dac_code | output | 24 | Output codes, channel i in bits [12*i+11:12*i] |
| upd_pulse | output | 2 | One-cycle load request per channel |
| irq_flag | output | 2 | Sticky load flag per channel |

## Verification
The group-mode property assumes that every channel was switched into group mode with no stale mark left from an earlier group period. The stimulus therefore configures all channels before it writes any group data, and it leaves group mode only after a group load has cleared the marks. The immediate-mode property reads the trigger select in force on the cycle of the write. For that reason the bench never writes a channel's control word and its data word on the same edge. Timer inputs move only on the falling clock edge and stay stable for several cycles, so each rising edge is seen exactly once after synchronization.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

  typedef enum logic [1:0] {
    LS_IMMED = 2'd0,
    LS_GROUP = 2'd1,
    LS_TMR_A = 2'd2,
    LS_TMR_B = 2'd3
  } lsel_e;

  // Control word layout, LSB first: trigger select, resolution, format.
  typedef struct packed {
    logic  twos;
    logic  res8;
    lsel_e lsel;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/dac_fmt_conv.sv
module dac_fmt_conv #(
  parameter int CODE_W   = 12,
  parameter int NARROW_W = 8
) (
  input  logic [CODE_W-1:0] data_i,
  input  logic              res8_i,
  input  logic              twos_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int PAD_W = CODE_W - NARROW_W;

  logic [CODE_W-1:0]   wide_code;
  logic [NARROW_W-1:0] narrow_code;

  always_comb begin
    wide_code   = data_i;
    narrow_code = data_i[NARROW_W-1:0];
    if (twos_i) begin
      wide_code[CODE_W-1]     = ~data_i[CODE_W-1];
      narrow_code[NARROW_W-1] = ~data_i[NARROW_W-1];
    end
    code_o = res8_i ? {{PAD_W{1'b0}}, narrow_code} : wide_code;
  end

endmodule

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_upd_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  chan_cfg_t         cfg_wdata,
  input  logic              data_we,
  input  logic [CODE_W-1:0] conv_code,
  input  logic              grp_fire,
  input  logic              tmr_a_rise,
  input  logic              tmr_b_rise,
  input  logic              flag_clr,
  output chan_cfg_t         cfg_q,
  output logic [CODE_W-1:0] code_q,
  output logic              grp_mark_q,
  output logic              upd_q,
  output logic              flag_q
);

  logic [CODE_W-1:0] pend_q;
  logic [CODE_W-1:0] code_d;
  logic              load_imm;
  logic              load_pend;
  logic              load;
  logic              mark_d;
  logic              flag_d;

  always_comb begin
    load_imm  = data_we && (cfg_q.lsel == LS_IMMED);
    load_pend = (grp_fire   && (cfg_q.lsel == LS_GROUP)) ||
                (tmr_a_rise && (cfg_q.lsel == LS_TMR_A)) ||
                (tmr_b_rise && (cfg_q.lsel == LS_TMR_B));
    load      = load_imm || load_pend;
    code_d    = load_imm ? conv_code : pend_q;
    mark_d    = (grp_fire ? 1'b0 : grp_mark_q) |
                (data_we && (cfg_q.lsel == LS_GROUP));
    flag_d    = (flag_q & ~flag_clr) | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      pend_q     <= '0;
      code_q     <= '0;
      grp_mark_q <= 1'b0;
      upd_q      <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_wdata;
      if (data_we) pend_q <= conv_code;
      if (load)    code_q <= code_d;
      grp_mark_q <= mark_d;
      upd_q      <= load;
      flag_q     <= flag_d;
    end
  end

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CODE_W      = 12,
  parameter int NARROW_W    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 * NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]        flag_clr,
  input  logic                     tmr_a,
  input  logic                     tmr_b,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0]        upd_pulse,
  output logic [NUM_CH-1:0]        irq_flag
);

  localparam int NUM_TMR = 2;

  logic [1:0]            rst_pipe_q;
  logic                  rst_n_s;
  logic [NUM_TMR-1:0]    tmr_async;
  logic [NUM_TMR-1:0]    tmr_rise;
  logic [NUM_CH-1:0]     grp_mark;
  logic                  grp_fire;
  logic [2*NUM_CH-1:0]   lsel_flat;
  logic                  unused_wr_hi;

  // Reset: asserted at once, released through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign tmr_async    = {tmr_b, tmr_a};
  assign unused_wr_hi = ^wr_data[CODE_W-1:CFG_W];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dac_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .async_i (tmr_async[t]),
      .rise_o  (tmr_rise[t])
    );
  end

  assign grp_fire = &grp_mark;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              data_we;
    logic              cfg_we;
    logic [CODE_W-1:0] conv_code;
    chan_cfg_t         cfg_q;

    assign data_we = wr_en && (wr_addr == ADDR_W'(i));
    assign cfg_we  = wr_en && (wr_addr == ADDR_W'(i + NUM_CH));

    dac_fmt_conv #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_conv (
      .data_i (wr_data),
      .res8_i (cfg_q.res8),
      .twos_i (cfg_q.twos),
      .code_o (conv_code)
    );

    dac_chan #(.CODE_W(CODE_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .cfg_we     (cfg_we),
      .cfg_wdata  (chan_cfg_t'(wr_data[CFG_W-1:0])),
      .data_we    (data_we),
      .conv_code  (conv_code),
      .grp_fire   (grp_fire),
      .tmr_a_rise (tmr_rise[0]),
      .tmr_b_rise (tmr_rise[1]),
      .flag_clr   (flag_clr[i]),
      .cfg_q      (cfg_q),
      .code_q     (dac_code[i*CODE_W +: CODE_W]),
      .grp_mark_q (grp_mark[i]),
      .upd_q      (upd_pulse[i]),
      .flag_q     (irq_flag[i])
    );

    assign lsel_flat[2*i +: 2] = cfg_q.lsel;
  end

endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk #(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [NUM_CH-1:0]        flag_clr,
  input logic [NUM_CH*CODE_W-1:0] dac_code,
  input logic [NUM_CH-1:0]        upd_pulse,
  input logic [NUM_CH-1:0]        irq_flag,
  input logic [2*NUM_CH-1:0]      lsel_flat
);

  logic all_grp;
  always_comb begin
    all_grp = 1'b1;
    for (int i = 0; i < NUM_CH; i++)
      if (lsel_flat[2*i +: 2] != 2'd1) all_grp = 1'b0;
  end

  // R6: with every channel grouped, loads happen together or not at all
  assert_group_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(all_grp) |-> (upd_pulse == '0 || &upd_pulse));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R9: an output code moves only alongside its request pulse
    assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse[i] |-> $stable(dac_code[i*CODE_W +: CODE_W]));

    // R5: an immediate-mode data write loads on its own edge
    assert_immed_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_addr == ADDR_W'(i) && lsel_flat[2*i +: 2] == 2'd0)
      |-> upd_pulse[i]);

    // R11: every load leaves the interrupt flag set
    assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse[i] |-> irq_flag[i]);

    // R11: a clear with no competing load empties the flag
    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_clr[i]) && !upd_pulse[i]) |-> !irq_flag[i]);
  end

endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .flag_clr  (flag_clr),
  .dac_code  (dac_code),
  .upd_pulse (upd_pulse),
  .irq_flag  (irq_flag),
  .lsel_flat (lsel_flat)
);

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [11:0] wr_data;
  logic [1:0]  flag_clr;
  logic        tmr_a;
  logic        tmr_b;
  logic [23:0] dac_code;
  logic [1:0]  upd_pulse;
  logic [1:0]  irq_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dac_update_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flag_clr  (flag_clr),
    .tmr_a     (tmr_a),
    .tmr_b     (tmr_b),
    .dac_code  (dac_code),
    .upd_pulse (upd_pulse),
    .irq_flag  (irq_flag)
  );

  function automatic logic [11:0] code_of(input int ch);
    return dac_code[ch*12 +: 12];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] addr, input logic [11:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input int ch, input logic [1:0] ls, input bit r8, input bit tc);
    wr(2'(ch + 2), {8'h00, tc, r8, ls});
  endtask

  // Raise a timer input, then return after the third edge (the load edge).
  task automatic pulse_tmr(input bit which_b);
    if (which_b) tmr_b = 1'b1; else tmr_a = 1'b1;
    idle(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] e0, e1;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    flag_clr = '0; tmr_a = 1'b0; tmr_b = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1 code0", code_of(0), 0);
    chk("R1 code1", code_of(1), 0);
    chk("R1 pulse", upd_pulse, 0);
    chk("R1 flags", irq_flag, 0);
    // R1: default mode is immediate 12-bit straight
    wr(2'd1, 12'hC3A);
    chk("R1 default immediate", code_of(1), 12'hC3A);

    // R3 / R5 exhaustive 12-bit sweep on channel 0, both formats
    for (int f = 0; f < 2; f++) begin
      set_cfg(0, 2'd0, 1'b0, f[0]);
      for (int v = 0; v < 4096; v++) begin
        wr(2'd0, 12'(v));
        chk("R3 R5 code0 12-bit", code_of(0), 12'(v) ^ (f[0] ? 12'h800 : 12'h000));
      end
    end
    // R10: pulse present on the load cycle and gone one cycle later
    wr(2'd0, 12'h055);
    chk("R10 pulse on load", upd_pulse, 2'b01);
    idle(1);
    chk("R10 pulse one cycle", upd_pulse, 2'b00);

    // R4 8-bit sweep on both channels, upper data bits carry junk
    for (int ch = 0; ch < 2; ch++)
      for (int f = 0; f < 2; f++) begin
        set_cfg(ch, 2'd0, 1'b1, f[0]);
        // R2: a control write leaves the output alone
        chk("R2 cfg write no load", upd_pulse, 2'b00);
        for (int v = 0; v < 256; v++) begin
          wr(2'(ch), {4'(v * 5 + 3), 8'(v)});
          chk("R4 code 8-bit", code_of(ch), {4'h0, 8'(v) ^ (f[0] ? 8'h80 : 8'h00)});
        end
      end

    // R6 group mode
    set_cfg(0, 2'd1, 1'b0, 1'b0);
    set_cfg(1, 2'd1, 1'b0, 1'b0);
    e0 = code_of(0); e1 = code_of(1);
    wr(2'd0, 12'h123);
    idle(3);
    chk("R6 single write held ch0", code_of(0), e0);
    chk("R6 single write held ch1", code_of(1), e1);
    chk("R6 no pulse", upd_pulse, 2'b00);
    wr(2'd1, 12'h456);
    chk("R6 not yet ch0", code_of(0), e0);
    chk("R6 not yet ch1", code_of(1), e1);
    idle(1);
    chk("R6 group ch0", code_of(0), 12'h123);
    chk("R6 group ch1", code_of(1), 12'h456);
    chk("R6 R10 both pulses", upd_pulse, 2'b11);
    // second group round, reverse order
    wr(2'd1, 12'hFED);
    wr(2'd0, 12'h0BA);
    chk("R6 hold before fire", code_of(1), 12'h456);
    idle(1);
    chk("R6 round2 ch0", code_of(0), 12'h0BA);
    chk("R6 round2 ch1", code_of(1), 12'hFED);

    // R7 timer A on channel 0
    set_cfg(0, 2'd2, 1'b0, 1'b0);
    set_cfg(1, 2'd0, 1'b0, 1'b0);
    wr(2'd0, 12'hABC);
    chk("R9 held after write", code_of(0), 12'h0BA);
    tmr_b = 1'b1; idle(5);
    chk("R7 tmr_b ignored", code_of(0), 12'h0BA);
    tmr_b = 1'b0; idle(5);
    tmr_a = 1'b1;
    idle(2);
    chk("R7 not before sync", code_of(0), 12'h0BA);
    idle(1);
    chk("R7 loaded", code_of(0), 12'hABC);
    chk("R7 R10 pulse", upd_pulse, 2'b01);
    tmr_a = 1'b0; idle(5);
    chk("R7 fall ignored", code_of(0), 12'hABC);
    chk("R7 fall no pulse", upd_pulse, 2'b00);
    pulse_tmr(1'b0);
    chk("R9 reload pulse", upd_pulse, 2'b01);
    chk("R9 reload same", code_of(0), 12'hABC);
    tmr_a = 1'b0; idle(4);

    // R12 format applied at write time
    set_cfg(0, 2'd2, 1'b0, 1'b1);
    wr(2'd0, 12'h123);
    set_cfg(0, 2'd2, 1'b1, 1'b0);
    pulse_tmr(1'b0);
    chk("R12 pending kept", code_of(0), 12'h923);
    tmr_a = 1'b0; idle(4);

    // R8 timer B on channel 1, 8-bit
    set_cfg(1, 2'd3, 1'b1, 1'b0);
    wr(2'd1, 12'h7F5);
    pulse_tmr(1'b0);
    idle(2);
    chk("R8 tmr_a ignored", code_of(1), 12'hFED);
    tmr_a = 1'b0; idle(4);
    tmr_b = 1'b1;
    idle(2);
    chk("R8 not before sync", code_of(1), 12'hFED);
    idle(1);
    chk("R8 loaded", code_of(1), 12'h0F5);
    chk("R8 pulse", upd_pulse, 2'b10);
    tmr_b = 1'b0; idle(4);

    // R11 flags
    chk("R11 sticky", irq_flag, 2'b11);
    flag_clr = 2'b01; idle(1); flag_clr = 2'b00;
    chk("R11 clear ch0", irq_flag, 2'b10);
    flag_clr = 2'b10; idle(1); flag_clr = 2'b00;
    chk("R11 clear ch1", irq_flag, 2'b00);
    set_cfg(0, 2'd0, 1'b0, 1'b0);
    flag_clr = 2'b01;
    wr(2'd0, 12'h321);
    flag_clr = 2'b00;
    chk("R11 set wins", irq_flag, 2'b01);
    idle(5);
    chk("R11 stays set", irq_flag, 2'b01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule